// File: doc/BRIEF.md
# Dual-Write Register File

This block holds the general-purpose registers of a simple sequential processor core. It has eight 32-bit entries and two read ports. The read ports are combinational, so the decode stage gets both operands within the cycle. It also has two write ports that commit on the rising clock edge. One write port carries the execute result and the other carries the value loaded from memory.

Every port is addressed by a 4-bit register identifier. Identifier 8 is the "no register" code. Any identifier at or above the entry count behaves the same way: a read returns zero and a write changes nothing.

Reads always show the register contents from before the current cycle's writes. An instruction therefore never sees its own update. For example, a push reads the stack pointer value it had before the push. When both write ports name the same entry in one cycle, the memory-result port wins. This is the case when a pop targets the stack pointer itself.

Top module: `rf_dual_wr`

## Requirements
- R1: While `rst_ni` is low, every entry reads as zero, and reset takes effect without waiting for a clock edge.
- R2: Each read port returns the current contents of the entry named by its identifier (0..7), and the two ports are independent.
- R3: The execute-result port writes `wr_e_data_i` into entry `wr_e_id_i` (0..7) on the rising clock edge.
- R4: The memory-result port writes `wr_m_data_i` into entry `wr_m_id_i` (0..7) on the rising clock edge.
- R5: When the two write ports name different entries, both writes take effect on the same edge.
- R6: When the two write ports name the same entry, that entry takes `wr_m_data_i`, and the execute-result value is dropped.
- R7: A read identifier of 8 or above (8..15) returns zero.
- R8: A write identifier of 8 or above changes no entry.
- R9: During the cycle in which a write is presented, a read of the same entry returns the old value. No forwarding takes place.
- R10: An entry named by neither write port keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes commit on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears all entries |
| rd_a_id_i | input | 4 | Read port A identifier; 8..15 means no register |
| rd_a_data_o | output | 32 | Read port A data (operand A) |
| rd_b_id_i | input | 4 | Read port B identifier; 8..15 means no register |
| rd_b_data_o | output | 32 | Read port B data (operand B) |
| wr_e_id_i | input | 4 | Execute-result write identifier; 8..15 disables the port |
| wr_e_data_i | input | 32 | Execute-result write data |
| wr_m_id_i | input | 4 | Memory-result write identifier; 8..15 disables the port |
| wr_m_data_i | input | 32 | Memory-result write data |

## Verification
The hardest situation to reach from the ports is a same-entry collision in which the two data values differ and the earlier contents are known. If the values were equal, or the contents unknown, the wrong winner would go unnoticed. The bench steps through all 256 pairs of write identifiers and gives each port its own distinct data on every step. That sweep covers every collision, every mix of a disabled port with an enabled one, and every disabled pair. Before each edge, the read ports point at the write targets to show the old values. After the edge, all sixteen read identifiers are scanned against an arithmetic model in which the memory-result port is applied last.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_ID_W   = 4;
  localparam int unsigned RF_DATA_W = 32;

  typedef enum logic [1:0] {
    SEL_HOLD = 2'd0,
    SEL_E    = 2'd1,
    SEL_M    = 2'd2
  } rf_sel_e;
endpackage

// File: rtl/rf_id_decode.sv
module rf_id_decode #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned ID_W     = 4
) (
  input  logic [ID_W-1:0]     id_i,
  output logic [NUM_REGS-1:0] hit_o
);
  // One-hot select; identifiers at or above NUM_REGS match no entry.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    assign hit_o[g] = (id_i == ID_W'(g));
  end
endmodule

// File: rtl/rf_entry.sv
module rf_entry
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              e_hit_i,
  input  logic              m_hit_i,
  input  logic [DATA_W-1:0] e_data_i,
  input  logic [DATA_W-1:0] m_data_i,
  output logic [DATA_W-1:0] q_o
);
  rf_sel_e     sel;
  logic [DATA_W-1:0] q;

  // Memory-result port has priority on collision.
  always_comb begin
    if (m_hit_i)      sel = SEL_M;
    else if (e_hit_i) sel = SEL_E;
    else              sel = SEL_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      unique case (sel)
        SEL_M:   q <= m_data_i;
        SEL_E:   q <= e_data_i;
        default: q <= q;
      endcase
    end
  end

  assign q_o = q;

  AST_M_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_hit_i |=> q_o == $past(m_data_i)); // R6
  AST_E_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_hit_i && !m_hit_i) |=> q_o == $past(e_data_i)); // R3
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!e_hit_i && !m_hit_i) |=> $stable(q_o)); // R10
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ID_W     = 4
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [ID_W-1:0]                 id_i,
  output logic [DATA_W-1:0]               data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (id_i == ID_W'(i)) data_o = regs_i[i];
    end
  end
endmodule

// File: rtl/rf_dual_wr.sv
module rf_dual_wr
  import rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = RF_DATA_W,
  parameter int unsigned ID_W     = RF_ID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   rd_a_id_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [ID_W-1:0]   rd_b_id_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic [ID_W-1:0]   wr_e_id_i,
  input  logic [DATA_W-1:0] wr_e_data_i,
  input  logic [ID_W-1:0]   wr_m_id_i,
  input  logic [DATA_W-1:0] wr_m_data_i
);
  logic [NUM_REGS-1:0]             e_hit, m_hit;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  rf_id_decode #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) i_dec_e (
    .id_i(wr_e_id_i), .hit_o(e_hit)
  );
  rf_id_decode #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) i_dec_m (
    .id_i(wr_m_id_i), .hit_o(m_hit)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    rf_entry #(.DATA_W(DATA_W)) i_entry (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .e_hit_i (e_hit[g]),
      .m_hit_i (m_hit[g]),
      .e_data_i(wr_e_data_i),
      .m_data_i(wr_m_data_i),
      .q_o     (regs_q[g])
    );
  end

  rf_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ID_W(ID_W)) i_rd_a (
    .regs_i(regs_q), .id_i(rd_a_id_i), .data_o(rd_a_data_o)
  );
  rf_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ID_W(ID_W)) i_rd_b (
    .regs_i(regs_q), .id_i(rd_b_id_i), .data_o(rd_b_data_o)
  );

  AST_RST_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (regs_q == '0)); // R1
  AST_DEC_E_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(e_hit)); // R3
  AST_DEC_M_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(m_hit)); // R4
  AST_RD_A_OOR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(rd_a_id_i) >= NUM_REGS) |-> (rd_a_data_o == '0)); // R7
  AST_RD_B_OOR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(rd_b_id_i) >= NUM_REGS) |-> (rd_b_data_o == '0)); // R7
  AST_WR_OOR_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(wr_e_id_i) >= NUM_REGS && int'(wr_m_id_i) >= NUM_REGS)
    |=> $stable(regs_q)); // R8
  AST_NO_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(rd_a_id_i) < NUM_REGS) |-> (rd_a_data_o == regs_q[rd_a_id_i[$clog2(NUM_REGS)-1:0]])); // R9
endmodule

// File: tb/test_rf_dual_wr.sv
module test_rf_dual_wr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_a_id, rd_b_id, wr_e_id, wr_m_id;
  logic [31:0] rd_a_data, rd_b_data, wr_e_data, wr_m_data;
  logic [31:0] model [8];
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rf_dual_wr i_rf_dual_wr (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_id_i(rd_a_id), .rd_a_data_o(rd_a_data),
    .rd_b_id_i(rd_b_id), .rd_b_data_o(rd_b_data),
    .wr_e_id_i(wr_e_id), .wr_e_data_i(wr_e_data),
    .wr_m_id_i(wr_m_id), .wr_m_data_i(wr_m_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_rd(input logic [3:0] id);
    return (id < 4'd8) ? model[id[2:0]] : 32'h0;
  endfunction

  task automatic scan(input string tag);
    for (int r = 0; r < 16; r++) begin
      rd_a_id = 4'(r);
      rd_b_id = 4'(15 - r);
      #1;
      check(tag, rd_a_data, expect_rd(4'(r)));
      check(tag, rd_b_data, expect_rd(4'(15 - r)));
    end
  endtask

  task automatic do_write(input logic [3:0] e, input logic [3:0] m,
                          input logic [31:0] ed, input logic [31:0] md,
                          input string tag);
    @(negedge clk);
    wr_e_id = e; wr_e_data = ed;
    wr_m_id = m; wr_m_data = md;
    rd_a_id = e; rd_b_id = m;
    #1;
    // R9: same-cycle read shows pre-write contents
    check("R9", rd_a_data, expect_rd(e));
    check("R9", rd_b_data, expect_rd(m));
    @(posedge clk);
    #1;
    if (e < 4'd8) model[e[2:0]] = ed;
    if (m < 4'd8) model[m[2:0]] = md;  // memory port applied last: R6
    wr_e_id = 4'd8; wr_m_id = 4'd8;
    scan(tag);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    string tag;
    rst_n = 1'b0;
    rd_a_id = 4'd0; rd_b_id = 4'd0;
    wr_e_id = 4'd8; wr_m_id = 4'd8;
    wr_e_data = '0; wr_m_data = '0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    #12;
    scan("R1");
    @(negedge clk);
    rst_n = 1'b1;

    // R2: fill distinct values through each port alone, then scan
    for (int i = 0; i < 8; i++)
      do_write(4'(i), 4'd8, 32'hC0DE_0000 + 32'(i) * 32'h111, 32'h0, "R2 R3");
    for (int i = 0; i < 8; i++)
      do_write(4'd15, 4'(i), 32'h0, 32'h5A00_0000 + 32'(i) * 32'h203, "R4 R7 R8");

    // Full sweep of write-identifier pairs
    for (int it = 0; it < 256; it++) begin
      logic [3:0] e, m;
      e = 4'(it >> 4);
      m = 4'(it);
      if (e < 4'd8 && e == m)       tag = "R6";
      else if (e < 4'd8 && m < 4'd8) tag = "R5";
      else if (e >= 4'd8 && m >= 4'd8) tag = "R8 R10";
      else                          tag = "R3 R4 R10";
      do_write(e, m, 32'h1000_0000 + 32'(it) * 32'h0001_0003,
               32'h8000_0000 + 32'(it) * 32'h0002_0005, tag);
    end

    // R1: asynchronous clear mid-run
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < 8; i++) model[i] = '0;
    scan("R1");
    @(negedge clk);
    rst_n = 1'b1;
    do_write(4'd4, 4'd4, 32'hDEAD_0001, 32'hBEEF_0002, "R6");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule